// File: doc/BRIEF.md
# Internet Checksum Accumulator

This unit builds a 16-bit ones'-complement Internet checksum from a series of register writes. Software (or any bus master) clears the running sum, then feeds data four, two or one byte at a time; the unit adds each 16-bit value with end-around carry. An internal odd/even byte alignment flag follows the byte count. Pieces of odd length therefore combine into the same result as one contiguous stream.

A 13-bit control register is written through two addresses: one sets the bits written as 1, the other clears them. The control bits choose the value loaded on a restart (all zeros or all ones) and whether the alignment flag can be saved and restored through data bit 16. They also choose how a read presents the sum: which half of the 32-bit word carries it, and whether it is byte-swapped, inverted or both. With the alignment flag saved and restored, a checksum can be split into separate chunks that are worked on at different times. Two read-only aliases return the swapped sum and the inverted sum whatever the control bits say.

Top module: `inet_csum_unit`

## Requirements
- R1: The control register resets to zero. A write to address 0 ORs the low 13 data bits into it. A write to address 1 clears every bit where the data has a 1. Reads of address 0 or 1 return the register zero-extended. Bit 0 always reads 0.
- R2: Writing 1 to control bit 0 through address 0 is a restart. It loads the sum with 0xFFFF when control bit 12 is 1 after that write, or with 0x0000 when it is 0, and resets the alignment flag to even (0). The sum and the flag both read as zero after reset.
- R3: A restart forces control bit 11 (expose alignment) to 0, even when the same write sets it.
- R4: A write to address 2 loads the sum from data bits 15:0 whatever the value of bit 10. It loads the alignment flag from data bit 16 only when control bit 11 is 1; otherwise the flag is left unchanged.
- R5: When control bit 10 is 1, a read of addresses 2, 3 or 4 returns the 16-bit value in bits 31:16. When bit 10 is 0, the value is in bits 15:0. All other bits are 0 except as stated in R6.
- R6: When control bit 11 is 1, those reads also return the alignment flag: in bit 0 when bit 10 is 1, and in bit 16 when bit 10 is 0.
- R7: A read of address 2 returns the sum byte-swapped when control bit 9 is 1, and bitwise inverted when control bit 8 is 1. Both bits set applies both. Neither bit alters the stored sum.
- R8: Address 3 always returns the byte-swapped sum and address 4 always returns the inverted sum, ignoring bits 9 and 8. Writes to addresses 3 and 4 change neither the sum nor the flag.
- R9: A write to address 5 adds data bits 31:16 and then bits 15:0 to the sum. A write to address 6 adds bits 15:0. Every addition is ones'-complement with end-around carry, and neither write changes the alignment flag.
- R10: While the alignment flag is odd (1), each incoming 16-bit value is byte-swapped before it is added. The result equals the checksum of the byte stream with bytes paired big-endian from the restart.
- R11: A write to address 7 adds the byte in data bits 7:0 as the high-order byte of a 16-bit value whose low byte is zero, swapped per R10, and toggles the alignment flag.
- R12: Read data appears on rdata on the clock edge that samples rd_en and holds until the next read. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
On every cycle the assertions check the control register's response to set and clear writes and the values loaded on restart. They also check that bit 11 drops on restart, that the alignment flag toggles only on single-byte feeds and stays put on hidden writes, and that alias writes leave the sum alone. The arithmetic itself can only be shown by the bench's scenarios. These are a sweep of every read-format control combination at both alignment values, and many streams of mixed-width feeds compared against a byte-stream checksum, some of them split in the middle and restored through bit 16.

// File: rtl/csum_pkg.sv
package csum_pkg;

   // Register word map; decode order is the behaviour of the bus.
   typedef enum logic [2:0] {
      A_CSET  = 3'd0,
      A_CCLR  = 3'd1,
      A_SUM   = 3'd2,
      A_SWP   = 3'd3,
      A_INV   = 3'd4,
      A_FEED4 = 3'd5,
      A_FEED2 = 3'd6,
      A_FEED1 = 3'd7
   } csum_addr_e;

   localparam int MAP_AW    = 3;

   // Control bit positions.
   localparam int B_ONES    = 12;
   localparam int B_EXPOSE  = 11;
   localparam int B_HIGH    = 10;
   localparam int B_SWAP    = 9;
   localparam int B_INVERT  = 8;
   localparam int B_RESTART = 0;

endpackage

// File: rtl/csum_ctrl_reg.sv
module csum_ctrl_reg
   import csum_pkg::*;
#(
   parameter int CTRL_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [CTRL_W-1:0] wbits,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              restart,
   output logic              ones_nxt
);

   localparam logic [CTRL_W-1:0] KEEP_MASK =
      ~((CTRL_W'(1) << B_EXPOSE) | (CTRL_W'(1) << B_RESTART));

   generate
      if (CTRL_W <= B_ONES) begin : g_bad_w
         $error("csum_ctrl_reg: CTRL_W too small for control bits");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_d;

   assign restart = set_we && wbits[B_RESTART];

   always_comb begin
      ctrl_d = ctrl_q;
      if (set_we) begin
         ctrl_d = ctrl_q | wbits;
      end else if (clr_we) begin
         ctrl_d = ctrl_q & ~wbits;
      end
      if (restart) begin
         ctrl_d[B_EXPOSE] = 1'b0;
      end
      ctrl_d[B_RESTART] = 1'b0;
   end

   assign ones_nxt = ctrl_d[B_ONES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         ctrl_q <= ctrl_d;
      end
   end

   assert_set_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((ctrl_q & $past(wbits) & KEEP_MASK) == ($past(wbits) & KEEP_MASK)));

   assert_clr_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((ctrl_q & $past(wbits)) == '0));

   assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(ctrl_q));

   assert_expose_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!ctrl_q[B_EXPOSE] && !ctrl_q[B_RESTART]));

endmodule

// File: rtl/csum_accum.sv
module csum_accum #(
   parameter int SUM_W = 16,
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             clr_ones,
   input  logic             load_we,
   input  logic [SUM_W-1:0] load_val,
   input  logic             load_align_en,
   input  logic             load_align,
   input  logic             feed_full,
   input  logic             feed_half,
   input  logic             feed_byte,
   input  logic [BUS_W-1:0] fdata,
   output logic [SUM_W-1:0] sum_q,
   output logic             align_q
);

   localparam int NLANE  = BUS_W / SUM_W;
   localparam int NBYTES = SUM_W / 8;

   generate
      if (SUM_W != 16) begin : g_bad_sum
         $error("csum_accum: two-state alignment needs SUM_W of 16");
      end
      if (BUS_W % SUM_W != 0) begin : g_bad_bus
         $error("csum_accum: BUS_W must be a multiple of SUM_W");
      end
   endgenerate

   function automatic logic [SUM_W-1:0] bswap(input logic [SUM_W-1:0] x);
      logic [SUM_W-1:0] r;
      for (int i = 0; i < NBYTES; i++) begin
         r[8*i +: 8] = x[SUM_W-8-8*i +: 8];
      end
      return r;
   endfunction

   function automatic logic [SUM_W-1:0] oc_add(input logic [SUM_W-1:0] a,
                                                input logic [SUM_W-1:0] b);
      logic [SUM_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, s[SUM_W]};
   endfunction

   // Lane chain for the full-width feed: most significant lane first.
   logic [SUM_W-1:0] chain [NLANE+1];
   assign chain[0] = sum_q;

   genvar g;
   generate
      for (g = 0; g < NLANE; g++) begin : g_lane
         logic [SUM_W-1:0] word;
         assign word = fdata[BUS_W-1-g*SUM_W -: SUM_W];
         assign chain[g+1] = oc_add(chain[g], align_q ? bswap(word) : word);
      end
   endgenerate

   logic [SUM_W-1:0] half_w, byte_w, half_sum, byte_sum;
   assign half_w   = fdata[SUM_W-1:0];
   assign byte_w   = {fdata[7:0], {(SUM_W-8){1'b0}}};
   assign half_sum = oc_add(sum_q, align_q ? bswap(half_w) : half_w);
   assign byte_sum = oc_add(sum_q, align_q ? bswap(byte_w) : byte_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q   <= '0;
         align_q <= 1'b0;
      end else if (restart) begin
         sum_q   <= {SUM_W{clr_ones}};
         align_q <= 1'b0;
      end else if (load_we) begin
         sum_q <= load_val;
         if (load_align_en) begin
            align_q <= load_align;
         end
      end else if (feed_full) begin
         sum_q <= chain[NLANE];
      end else if (feed_half) begin
         sum_q <= half_sum;
      end else if (feed_byte) begin
         sum_q   <= byte_sum;
         align_q <= ~align_q;
      end
   end

   assert_restart_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (sum_q == {SUM_W{$past(clr_ones)}} && !align_q));

   assert_hidden_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_we && !restart && !load_align_en) |=> $stable(align_q));

   assert_wide_keeps_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((feed_full || feed_half) && !restart && !load_we) |=> $stable(align_q));

   assert_byte_toggles_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_byte && !restart && !load_we && !feed_full && !feed_half)
         |=> (align_q != $past(align_q)));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(restart || load_we || feed_full || feed_half || feed_byte)
         |=> ($stable(sum_q) && $stable(align_q)));

endmodule

// File: rtl/csum_rdfmt.sv
module csum_rdfmt
   import csum_pkg::*;
#(
   parameter int SUM_W     = 16,
   parameter int BUS_W     = 32,
   parameter int CTRL_W    = 13,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              rd_hit,
   input  csum_addr_e        rd_sel,
   input  logic [CTRL_W-1:0] ctrl_q,
   input  logic [SUM_W-1:0]  sum_q,
   input  logic              align_q,
   output logic [BUS_W-1:0]  rdata
);

   localparam int NBYTES = SUM_W / 8;
   localparam int PAD_W  = BUS_W - SUM_W;

   generate
      if (PAD_W < SUM_W) begin : g_bad_bus
         $error("csum_rdfmt: BUS_W must hold two sum halves");
      end
   endgenerate

   function automatic logic [SUM_W-1:0] bswap(input logic [SUM_W-1:0] x);
      logic [SUM_W-1:0] r;
      for (int i = 0; i < NBYTES; i++) begin
         r[8*i +: 8] = x[SUM_W-8-8*i +: 8];
      end
      return r;
   endfunction

   logic [SUM_W-1:0] view;
   logic [BUS_W-1:0] placed, word;

   always_comb begin
      view = sum_q;
      unique case (rd_sel)
         A_SUM: begin
            if (ctrl_q[B_SWAP])   view = bswap(view);
            if (ctrl_q[B_INVERT]) view = ~view;
         end
         A_SWP:   view = bswap(sum_q);
         A_INV:   view = ~sum_q;
         default: view = sum_q;
      endcase

      if (ctrl_q[B_HIGH]) begin
         placed = {view, {PAD_W{1'b0}}};
      end else begin
         placed = {{PAD_W{1'b0}}, view};
      end
      if (ctrl_q[B_EXPOSE]) begin
         if (ctrl_q[B_HIGH]) placed[0]     = align_q;
         else                placed[SUM_W] = align_q;
      end

      word = '0;
      if (rd_hit) begin
         unique case (rd_sel)
            A_CSET, A_CCLR:      word = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
            A_SUM, A_SWP, A_INV: word = placed;
            default:             word = '0;
         endcase
      end
   end

   generate
      if (REG_RDATA) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata <= '0;
            end else if (rd_en) begin
               rdata <= word;
            end
         end

         assert_feed_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (rd_sel == A_FEED4 || rd_sel == A_FEED2 || rd_sel == A_FEED1))
               |=> (rdata == '0));

         assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> $stable(rdata));

         assert_high_place_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_hit && ctrl_q[B_HIGH] &&
             (rd_sel == A_SUM || rd_sel == A_SWP || rd_sel == A_INV))
               |=> (rdata[SUM_W-1:1] == '0));
      end else begin : g_comb
         assign rdata = word;
      end
   endgenerate

endmodule

// File: rtl/inet_csum_unit.sv
module inet_csum_unit
   import csum_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int BUS_W     = 32,
   parameter int SUM_W     = 16,
   parameter int CTRL_W    = 13,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata
);

   generate
      if (ADDR_W < MAP_AW) begin : g_bad_aw
         $error("inet_csum_unit: ADDR_W too small for the register map");
      end
      if (BUS_W != 2 * SUM_W) begin : g_bad_bus
         $error("inet_csum_unit: BUS_W must be twice SUM_W");
      end
      if (CTRL_W > BUS_W) begin : g_bad_ctrl
         $error("inet_csum_unit: CTRL_W wider than the bus");
      end
   endgenerate

   csum_addr_e sel;
   logic       in_map;

   assign sel    = csum_addr_e'(addr[MAP_AW-1:0]);
   assign in_map = (addr >> MAP_AW) == '0;

   logic wr_hit;
   assign wr_hit = wr_en && in_map;

   logic [CTRL_W-1:0] ctrl_q;
   logic              restart, ones_nxt;
   logic [SUM_W-1:0]  sum_q;
   logic              align_q;

   csum_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (wr_hit && sel == A_CSET),
      .clr_we   (wr_hit && sel == A_CCLR),
      .wbits    (wdata[CTRL_W-1:0]),
      .ctrl_q   (ctrl_q),
      .restart  (restart),
      .ones_nxt (ones_nxt)
   );

   csum_accum #(.SUM_W(SUM_W), .BUS_W(BUS_W)) u_accum (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart       (restart),
      .clr_ones      (ones_nxt),
      .load_we       (wr_hit && sel == A_SUM),
      .load_val      (wdata[SUM_W-1:0]),
      .load_align_en (ctrl_q[B_EXPOSE]),
      .load_align    (wdata[SUM_W]),
      .feed_full     (wr_hit && sel == A_FEED4),
      .feed_half     (wr_hit && sel == A_FEED2),
      .feed_byte     (wr_hit && sel == A_FEED1),
      .fdata         (wdata),
      .sum_q         (sum_q),
      .align_q       (align_q)
   );

   csum_rdfmt #(
      .SUM_W     (SUM_W),
      .BUS_W     (BUS_W),
      .CTRL_W    (CTRL_W),
      .REG_RDATA (REG_RDATA)
   ) u_rdfmt (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_hit  (in_map),
      .rd_sel  (sel),
      .ctrl_q  (ctrl_q),
      .sum_q   (sum_q),
      .align_q (align_q),
      .rdata   (rdata)
   );

   assert_alias_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && (sel == A_SWP || sel == A_INV)) |=> ($stable(sum_q) && $stable(align_q)));

endmodule

// File: tb/inet_csum_unit_tb_top.sv
`timescale 1ns/1ps
module inet_csum_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [12:0] m_ctrl;
   longint      m_acc;
   bit          m_par;

   always #2.5 clk = ~clk;

   inet_csum_unit dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a[2:0]; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a[2:0];
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic set_ctrl(input logic [12:0] m);
      bus_write(0, {19'b0, m});
      m_ctrl = m_ctrl | m;
      if (m[0]) m_ctrl[11] = 1'b0;
      m_ctrl[0] = 1'b0;
   endtask

   task automatic clr_ctrl(input logic [12:0] m);
      bus_write(1, {19'b0, m});
      m_ctrl = m_ctrl & ~m;
   endtask

   function automatic logic [15:0] fold(input longint t);
      longint x = t;
      while ((x >> 16) != 0) x = (x & 64'hFFFF) + (x >> 16);
      return x[15:0];
   endfunction

   function automatic logic [31:0] fmt(input logic [15:0] v, input bit sw, input bit inv,
                                       input bit hi, input bit ex, input bit al);
      logic [15:0] u = v;
      logic [31:0] w;
      if (sw)  u = {u[7:0], u[15:8]};
      if (inv) u = ~u;
      w = hi ? {u, 16'h0} : {16'h0, u};
      if (ex) begin
         if (hi) w[0] = al; else w[16] = al;
      end
      return w;
   endfunction

   // Stream model: bytes paired big-endian from the restart point.
   task automatic push_byte(input logic [7:0] b);
      m_acc = m_acc + (m_par ? longint'(b) : longint'(b) << 8);
      m_par = ~m_par;
   endtask

   task automatic restart(input bit ones);
      if (ones) set_ctrl(13'h1000); else clr_ctrl(13'h1000);
      set_ctrl(13'h0001);
      m_acc = ones ? 64'hFFFF : 64'h0;
      m_par = 1'b0;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d, e;
      m_ctrl = '0; m_acc = 0; m_par = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // Reset state (R1, R2, R12)
      bus_read(0, d); chk(d == 32'h0, "R1 ctrl after reset", d, 32'h0);
      bus_read(2, d); chk(d == 32'h0, "R2 sum after reset", d, 32'h0);

      // Set / clear semantics (R1)
      set_ctrl(13'h1F5A);
      bus_read(0, d); chk(d == {19'b0, m_ctrl}, "R1 set write", d, {19'b0, m_ctrl});
      clr_ctrl(13'h0A12);
      bus_read(1, d); chk(d == {19'b0, m_ctrl}, "R1 clear write", d, {19'b0, m_ctrl});
      clr_ctrl(13'h1FFF);
      bus_read(0, d); chk(d == 32'h0, "R1 clear all", d, 32'h0);

      // Restart drops expose even when set together (R3), bit 0 reads 0 (R1)
      set_ctrl(13'h0801);
      bus_read(0, d); chk(d == 32'h0, "R3 expose dropped on restart", d, 32'h0);
      set_ctrl(13'h0800);
      set_ctrl(13'h0001);
      bus_read(0, d); chk(d[11] == 1'b0, "R3 expose cleared by later restart", d, 32'h0);

      // Restart values (R2)
      restart(1'b1);
      bus_read(2, d); chk(d == 32'h0000_FFFF, "R2 restart to ones", d, 32'h0000_FFFF);
      restart(1'b0);
      bus_read(2, d); chk(d == 32'h0, "R2 restart to zero", d, 32'h0);
      // ones bit set in the same write as restart
      bus_write(0, 32'h0000_1001); m_ctrl[12] = 1'b1;
      bus_read(2, d); chk(d == 32'h0000_FFFF, "R2 ones with restart write", d, 32'h0000_FFFF);

      // Read-format sweep over bits 12..8 at both alignments (R5, R6, R7, R8)
      for (int al = 0; al < 2; al++) begin
         clr_ctrl(13'h1FFF);
         set_ctrl(13'h0800);
         bus_write(2, {15'b0, al[0], 16'h12A5});
         for (int c = 0; c < 32; c++) begin
            clr_ctrl(13'h1F00);
            set_ctrl({c[4:0], 8'h00});
            bus_read(2, d);
            e = fmt(16'h12A5, c[1], c[0], c[2], c[3], al[0]);
            chk(d == e, "R5 R6 R7 data read format", d, e);
            bus_read(3, d);
            e = fmt(16'h12A5, 1'b1, 1'b0, c[2], c[3], al[0]);
            chk(d == e, "R8 swapped alias", d, e);
            bus_read(4, d);
            e = fmt(16'h12A5, 1'b0, 1'b1, c[2], c[3], al[0]);
            chk(d == e, "R8 inverted alias", d, e);
         end
      end
      clr_ctrl(13'h1FFF);
      bus_read(2, d); chk(d == 32'h0000_12A5, "R7 stored sum unchanged by reads", d, 32'h0000_12A5);

      // Hidden alignment on write, high half ignored on write (R4)
      set_ctrl(13'h0800);
      bus_write(2, 32'h0001_0000);
      clr_ctrl(13'h0800);
      set_ctrl(13'h0400);
      bus_write(2, 32'hABCC_5678);
      clr_ctrl(13'h0400);
      set_ctrl(13'h0800);
      bus_read(2, d); chk(d == 32'h0001_5678, "R4 low half loaded, flag kept", d, 32'h0001_5678);
      bus_write(2, 32'h0000_5678);
      bus_read(2, d); chk(d == 32'h0000_5678, "R4 exposed write loads flag", d, 32'h0000_5678);

      // Alias writes ignored (R8), feed reads zero (R12)
      bus_write(3, 32'h0001_FFFF);
      bus_write(4, 32'h0001_0000);
      bus_read(2, d); chk(d == 32'h0000_5678, "R8 alias writes ignored", d, 32'h0000_5678);
      for (int a = 5; a < 8; a++) begin
         bus_read(a, d); chk(d == 32'h0, "R12 feed address reads zero", d, 32'h0);
      end

      // End-around carry (R9)
      restart(1'b0);
      bus_write(6, 32'h0000_FFFF);
      bus_write(6, 32'h0000_0001);
      bus_read(2, d); chk(d == 32'h1, "R9 end-around carry", d, 32'h1);

      // Byte feeds and odd swapping (R10, R11)
      restart(1'b0);
      set_ctrl(13'h0800);
      bus_write(7, 32'h0000_0012);
      bus_read(2, d); chk(d == 32'h0001_1200, "R11 first byte high, flag odd", d, 32'h0001_1200);
      bus_write(7, 32'h0000_0034);
      bus_read(2, d); chk(d == 32'h0000_1234, "R11 second byte low, flag even", d, 32'h0000_1234);
      restart(1'b0);
      set_ctrl(13'h0800);
      bus_write(7, 32'h0000_00AA);
      bus_write(6, 32'h0000_BBCC);
      bus_read(2, d); chk(d == 32'h0001_76BC, "R10 half feed at odd alignment", d, 32'h0001_76BC);

      // Mixed streams, some split and restored through bit 16 (R4, R6, R9, R10, R11)
      for (int t = 0; t < 40; t++) begin
         int nops;
         restart(t[0]);
         set_ctrl(13'h0800);
         nops = 4 + int'($urandom_range(0, 20));
         for (int k = 0; k < nops; k++) begin
            logic [31:0] w;
            int kind;
            w = $urandom;
            kind = int'($urandom_range(0, 2));
            if (kind == 0) begin
               bus_write(5, w);
               push_byte(w[31:24]); push_byte(w[23:16]);
               push_byte(w[15:8]);  push_byte(w[7:0]);
            end else if (kind == 1) begin
               bus_write(6, w);
               push_byte(w[15:8]); push_byte(w[7:0]);
            end else begin
               bus_write(7, w);
               push_byte(w[7:0]);
            end
            if (k == nops / 2 && t[1]) begin
               logic [31:0] saved;
               bus_read(2, saved);
               e = {15'b0, m_par, fold(m_acc)};
               chk(saved == e, "R6 mid-stream save", saved, e);
               restart(1'b0);
               m_acc = longint'(saved[15:0]);
               m_par = saved[16];
               set_ctrl(13'h0800);
               bus_write(2, saved);
            end
         end
         bus_read(2, d);
         e = {15'b0, m_par, fold(m_acc)};
         chk(d == e, "R9 R10 R11 stream checksum", d, e);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule